// File: doc/BRIEF.md
# Configuration Memory Scrubbing Controller

This controller keeps a frame-organised configuration memory consistent with a golden image. After each idle interval it walks the frames in ascending order and reads every word back. It compares each word with a golden value that it computes on chip. When a frame holds a wrong word, the controller rewrites that frame alone and leaves the rest of the device untouched. It then reads that frame back once more to confirm the repair. Frames that share their output path with user memory are never read during a scrub.

A functional-interrupt input overrides the normal flow, because readback cannot be trusted once an interrupt has occurred. The controller drops any pass in progress and holds a device-reset request for a fixed number of cycles. It then rewrites every frame, and it flags the user function as offline for the whole of this recovery.

Top module: `cfg_scrubber`

## Requirements
- R1: While `rst_n` is low, `cfg_rd`, `cfg_wr`, `busy`, `dev_reset`, `user_offline`, `persist_fault`, `err_count` and `last_frame` are all zero.
- R2: The golden word at linear address a = frame*WORDS + word is (a*37 + 90) mod 2^DW. Every rewrite drives this value on `cfg_wdata`. The address `cfg_addr` is {frame, word}.
- R3: After a pass ends, `busy` stays low for `scrub_interval`+1 cycles. The next pass then starts at frame 0, and reads never go back to a lower frame within a pass.
- R4: A pass over a memory that matches the golden image makes no writes and leaves `err_count` unchanged. Each compared frame is read once per word.
- R5: A frame with any mismatching word is rewritten completely with golden data, and no other frame is written. `dev_reset` and `user_offline` stay low during this partial repair.
- R6: Each repaired frame adds one to `err_count`, which saturates at 2^CW-1. `last_frame` holds the index of the most recently repaired frame.
- R7: A repaired frame is read once more. If that second read still mismatches, `persist_fault` is set, and it stays set until reset.
- R8: A frame whose bit is set in the parameter EXCL (default frame 2) is never read, and a corrupt word in it is not repaired by a scrub pass.
- R9: When `sefi` is high and the block is not offline, the pass is abandoned. In the next cycle `dev_reset` goes high and stays high for RST_CYC cycles. All NFRAMES*WORDS words are then rewritten with golden data. `user_offline` is high for all of these cycles, and no read takes place while it is high.
- R10: `cfg_rd` and `cfg_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_interval | input | IW | Idle cycles between passes, minus one |
| sefi | input | 1 | Functional-interrupt indication |
| cfg_addr | output | log2(NFRAMES)+log2(WORDS) | Frame and word address |
| cfg_rd | output | 1 | Read strobe; data is expected on cfg_rdata in the same cycle |
| cfg_wr | output | 1 | Write strobe |
| cfg_wdata | output | DW | Golden write data |
| cfg_rdata | input | DW | Read-back data |
| dev_reset | output | 1 | Full device reset request |
| user_offline | output | 1 | User function unavailable |
| busy | output | 1 | A pass or a recovery is in progress |
| err_count | output | CW | Saturating count of repaired frames |
| last_frame | output | log2(NFRAMES) | Most recently repaired frame |
| persist_fault | output | 1 | Sticky failed-repair flag |

## Verification
The bench first runs a clean pass, which separates a scrubber that writes without cause from one that writes only on a mismatch. It then sweeps a single flipped bit over every word of every compared frame. This shows that any word position can trigger a repair, and that only the faulty frame is rewritten. Further patterns cover a corrupt excluded frame, two corrupt frames in one pass, enough repairs to pass the counter limit, and a stuck bit that survives its rewrite. These tell apart the exclusion rule, the ordering of `last_frame`, saturation and the second readback. Interrupts arrive both in the middle of a pass and while idle, and the bench counts the reset and offline cycles for each.

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
  parameter int NFRAMES = 4,
  parameter int WORDS   = 4,
  parameter int DW      = 8,
  parameter int IW      = 16,
  parameter int CW      = 8,
  parameter int RST_CYC = 4,
  parameter logic [NFRAMES-1:0] EXCL = 4'b0100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IW-1:0]         scrub_interval,
  input  logic                  sefi,
  output logic [$clog2(NFRAMES)+$clog2(WORDS)-1:0] cfg_addr,
  output logic                  cfg_rd,
  output logic                  cfg_wr,
  output logic [DW-1:0]         cfg_wdata,
  input  logic [DW-1:0]         cfg_rdata,
  output logic                  dev_reset,
  output logic                  user_offline,
  output logic                  busy,
  output logic [CW-1:0]         err_count,
  output logic [$clog2(NFRAMES)-1:0] last_frame,
  output logic                  persist_fault
);
  localparam int FAW = $clog2(NFRAMES);
  localparam int WAW = $clog2(WORDS);
  localparam int AW  = FAW + WAW;
  localparam int RW  = $clog2(RST_CYC) + 1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_VERIFY, S_RESET, S_FULL} st_t;

  st_t            st;
  logic [IW-1:0]  tmr;
  logic [FAW-1:0] frm;
  logic [WAW-1:0] wrd;
  logic           mm;
  logic [RW-1:0]  rcnt;

  function automatic logic [DW-1:0] golden(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd37 + 32'd90;
    return t[DW-1:0];
  endfunction

  wire last_w = (wrd == WAW'(WORDS - 1));
  wire last_f = (frm == FAW'(NFRAMES - 1));
  wire skip   = EXCL[frm];
  wire hit    = (cfg_rdata != golden(cfg_addr));
  wire bad    = mm | hit;

  assign cfg_addr     = {frm, wrd};
  assign cfg_rd       = (st == S_READ && !skip) || st == S_VERIFY;
  assign cfg_wr       = (st == S_WRITE) || (st == S_FULL);
  assign cfg_wdata    = golden(cfg_addr);
  assign dev_reset    = (st == S_RESET);
  assign user_offline = (st == S_RESET) || (st == S_FULL);
  assign busy         = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      frm <= '0;
      wrd <= '0;
      mm <= 1'b0;
      rcnt <= '0;
      err_count <= '0;
      last_frame <= '0;
      persist_fault <= 1'b0;
    end else if (sefi && !user_offline) begin
      st <= S_RESET;
      rcnt <= '0;
      mm <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (tmr >= scrub_interval) begin
            tmr <= '0;
            frm <= '0;
            wrd <= '0;
            mm <= 1'b0;
            st <= S_READ;
          end else tmr <= tmr + 1'b1;
        S_READ, S_VERIFY: begin
          if ((st == S_READ && skip) || last_w) begin
            wrd <= '0;
            mm <= 1'b0;
            if (st == S_READ && !skip && bad) st <= S_WRITE;
            else begin
              if (st == S_VERIFY && bad) persist_fault <= 1'b1;
              if (last_f) st <= S_IDLE;
              else begin
                frm <= frm + 1'b1;
                st <= S_READ;
              end
            end
          end else begin
            wrd <= wrd + 1'b1;
            mm <= bad;
          end
        end
        S_WRITE: begin
          wrd <= wrd + 1'b1;
          if (last_w) begin
            st <= S_VERIFY;
            last_frame <= frm;
            if (err_count != {CW{1'b1}}) err_count <= err_count + 1'b1;
          end
        end
        S_RESET: begin
          rcnt <= rcnt + 1'b1;
          if (rcnt == RW'(RST_CYC - 1)) begin
            st <= S_FULL;
            frm <= '0;
            wrd <= '0;
          end
        end
        S_FULL: begin
          {frm, wrd} <= {frm, wrd} + 1'b1;
          if (last_f && last_w) begin
            st <= S_IDLE;
            tmr <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_scrubber_chk.sv
module cfg_scrubber_chk #(
  parameter int NFRAMES = 4,
  parameter int WORDS   = 4,
  parameter int AW      = 4,
  parameter int CW      = 8,
  parameter logic [NFRAMES-1:0] EXCL = 4'b0100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sefi,
  input logic [AW-1:0] cfg_addr,
  input logic          cfg_rd,
  input logic          cfg_wr,
  input logic          dev_reset,
  input logic          user_offline,
  input logic [CW-1:0] err_count,
  input logic          persist_fault
);
  localparam int WAW = $clog2(WORDS);

  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd && cfg_wr));
  a_r9_reset_is_offline: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> user_offline);
  a_r9_sefi_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (sefi && !user_offline) |=> dev_reset);
  a_r9_no_read_offline: assert property (@(posedge clk) disable iff (!rst_n)
    user_offline |-> !cfg_rd);
  a_r8_excluded_unread: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |-> !EXCL[cfg_addr[AW-1:WAW]]);
  a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    err_count >= $past(err_count));
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    persist_fault |=> persist_fault);
endmodule

bind cfg_scrubber cfg_scrubber_chk #(
  .NFRAMES(NFRAMES), .WORDS(WORDS), .AW($clog2(NFRAMES)+$clog2(WORDS)),
  .CW(CW), .EXCL(EXCL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sefi(sefi), .cfg_addr(cfg_addr),
  .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .dev_reset(dev_reset),
  .user_offline(user_offline), .err_count(err_count),
  .persist_fault(persist_fault)
);

// File: tb/sim_cfg_scrubber.sv
module sim_cfg_scrubber;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4, NW = 4, DW = 8, CW = 4, RC = 4;
  localparam int NA = NF * NW;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, sefi = 0;
  logic [15:0] scrub_interval = 16'd20;
  logic [3:0] cfg_addr;
  logic cfg_rd, cfg_wr, dev_reset, user_offline, busy, persist_fault;
  logic [DW-1:0] cfg_wdata, cfg_rdata;
  logic [CW-1:0] err_count;
  logic [1:0] last_frame;

  logic [DW-1:0] mem [NA];
  logic inj = 0;
  logic [3:0] inj_a = 0;
  logic [DW-1:0] inj_v = 0;
  logic stuck_en = 0;
  logic [3:0] stuck_a = 0;
  logic [DW-1:0] stuck_m = 0;

  int wr_cnt [NF];
  int rd_cnt [NF];
  int rst_cyc = 0, off_cyc = 0, rd_off = 0, order_bad = 0, prev_f = 0, cyc = 0;
  int checks = 0, failures = 0;
  int exp_err = 0;

  cfg_scrubber #(.NFRAMES(NF), .WORDS(NW), .DW(DW), .IW(16), .CW(CW), .RST_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .scrub_interval(scrub_interval), .sefi(sefi),
    .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dev_reset(dev_reset), .user_offline(user_offline),
    .busy(busy), .err_count(err_count), .last_frame(last_frame),
    .persist_fault(persist_fault));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cfg_rdata = mem[cfg_addr] | ((stuck_en && cfg_addr == stuck_a) ? stuck_m : '0);

  function automatic logic [DW-1:0] gold(input int a);
    return DW'((a * 37 + 90) % 256);
  endfunction

  initial for (int i = 0; i < NF; i++) begin wr_cnt[i] = 0; rd_cnt[i] = 0; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (inj) mem[inj_a] <= inj_v;
    if (cfg_wr) begin
      mem[cfg_addr] <= cfg_wdata;
      wr_cnt[cfg_addr / NW] <= wr_cnt[cfg_addr / NW] + 1;
    end
    if (cfg_rd) begin
      rd_cnt[cfg_addr / NW] <= rd_cnt[cfg_addr / NW] + 1;
      if (int'(cfg_addr / NW) < prev_f) order_bad <= order_bad + 1;
      prev_f <= cfg_addr / NW;
      if (user_offline) rd_off <= rd_off + 1;
    end
    if (!busy) prev_f <= 0;
    if (dev_reset) rst_cyc <= rst_cyc + 1;
    if (user_offline) off_cyc <= off_cyc + 1;
  end

  always @(posedge clk) if (cyc > 150000) begin
    failures++;
    $display("FAIL watchdog: run did not finish (act=%0d cycles, exp<150000)", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] v);
    inj_a = 4'(a); inj_v = v; inj = 1;
    @(negedge clk);
    inj = 0;
  endtask

  task automatic run_pass();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  int sw[NF], sr[NF];
  int s_rst, s_off, s_rdoff;
  task automatic snap();
    for (int i = 0; i < NF; i++) begin sw[i] = wr_cnt[i]; sr[i] = rd_cnt[i]; end
    s_rst = rst_cyc; s_off = off_cyc; s_rdoff = rd_off;
  endtask
  function automatic int wtot();
    int t = 0;
    for (int i = 0; i < NF; i++) t += wr_cnt[i] - sw[i];
    return t;
  endfunction

  function automatic int sat(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  initial begin
    for (int a = 0; a < NA; a++) poke(a, gold(a));
    @(negedge clk);
    chk(!cfg_rd && !cfg_wr && !busy && !dev_reset && !user_offline, "R1 strobes", 0, 0);
    chk(err_count == 0 && last_frame == 0 && !persist_fault, "R1 status", err_count, 0);
    rst_n = 1;

    // R4 / R3 / R8 clean pass
    snap();
    run_pass();
    chk(wtot() == 0, "R4 clean writes", wtot(), 0);
    chk(err_count == 0, "R4 clean count", err_count, 0);
    for (int f = 0; f < NF; f++)
      if (f == 2) chk(rd_cnt[f] - sr[f] == 0, "R8 excluded reads", rd_cnt[f] - sr[f], 0);
      else chk(rd_cnt[f] - sr[f] == NW, "R4 reads per frame", rd_cnt[f] - sr[f], NW);
    chk(order_bad == 0, "R3 frame order", order_bad, 0);

    // R3 interval sweep
    foreach (scrub_interval[i]) ;
    for (int k = 0; k < 3; k++) begin
      int iv, n;
      iv = (k == 0) ? 0 : (k == 1) ? 3 : 9;
      while (!busy) @(negedge clk);
      scrub_interval = 16'(iv);
      while (busy) @(negedge clk);
      n = 1;
      forever begin
        @(negedge clk);
        if (busy) break;
        n++;
      end
      chk(n == iv + 1, "R3 idle length", n, iv + 1);
      chk(cfg_rd && cfg_addr == 0, "R3 starts at frame 0", cfg_addr, 0);
    end
    scrub_interval = 16'd20;
    while (busy) @(negedge clk);
    run_pass();

    // R5 / R6 / R2 single-bit sweep over compared frames
    for (int f = 0; f < NF; f++) begin
      if (f == 2) continue;
      for (int w = 0; w < NW; w++) begin
        int a;
        a = f * NW + w;
        poke(a, gold(a) ^ DW'(1 << w));
        snap();
        run_pass();
        exp_err++;
        chk(wr_cnt[f] - sw[f] == NW && wtot() == NW, "R5 only faulty frame rewritten", wtot(), NW);
        chk(mem[a] == gold(a), "R2 golden data restored", mem[a], gold(a));
        chk(err_count == sat(exp_err), "R6 count", err_count, sat(exp_err));
        chk(last_frame == f, "R6 last frame", last_frame, f);
        chk(rst_cyc == s_rst && off_cyc == s_off, "R5 user stays online", off_cyc - s_off, 0);
        chk(!persist_fault, "R7 no false fault", persist_fault, 0);
      end
    end

    // R8 corrupt excluded frame
    poke(9, gold(9) ^ 8'hFF);
    snap();
    run_pass();
    chk(wtot() == 0, "R8 excluded not written", wtot(), 0);
    chk(mem[9] == (gold(9) ^ 8'hFF), "R8 excluded stays corrupt", mem[9], gold(9) ^ 8'hFF);
    chk(err_count == sat(exp_err), "R8 count unchanged", err_count, sat(exp_err));

    // R6 two faulty frames, then saturation
    poke(1, gold(1) ^ 8'h10);
    poke(14, gold(14) ^ 8'h02);
    snap();
    run_pass();
    exp_err += 2;
    chk(wtot() == 2 * NW, "R5 two frames rewritten", wtot(), 2 * NW);
    chk(last_frame == 3, "R6 last frame is highest repaired", last_frame, 3);
    chk(err_count == sat(exp_err), "R6 count two", err_count, sat(exp_err));
    for (int k = 0; k < 3; k++) begin
      poke(6, gold(6) ^ 8'h40);
      run_pass();
      exp_err++;
      chk(err_count == sat(exp_err), "R6 saturation", err_count, sat(exp_err));
    end

    // R7 persistent fault
    stuck_a = 4'd5;
    stuck_m = (~gold(5)) & (-(~gold(5)));
    stuck_en = 1;
    snap();
    run_pass();
    stuck_en = 0;
    chk(persist_fault, "R7 fault raised", persist_fault, 1);
    chk(rd_cnt[1] - sr[1] == 2 * NW, "R7 verify reread", rd_cnt[1] - sr[1], 2 * NW);
    run_pass();
    chk(persist_fault, "R7 fault sticky", persist_fault, 1);

    // R9 interrupt mid-pass
    while (!(cfg_rd && cfg_addr / NW == 1)) @(negedge clk);
    snap();
    sefi = 1;
    @(negedge clk);
    sefi = 0;
    chk(dev_reset && user_offline, "R9 reset next cycle", dev_reset, 1);
    while (user_offline) @(negedge clk);
    chk(rst_cyc - s_rst == RC, "R9 reset length", rst_cyc - s_rst, RC);
    chk(off_cyc - s_off == RC + NA, "R9 offline length", off_cyc - s_off, RC + NA);
    chk(wtot() == NA, "R9 full rewrite", wtot(), NA);
    chk(rd_off == s_rdoff, "R9 no reads offline", rd_off - s_rdoff, 0);
    for (int a = 0; a < NA; a++)
      if (mem[a] != gold(a)) chk(0, "R9 golden image", mem[a], gold(a));
    chk(mem[9] == gold(9), "R9 excluded frame restored", mem[9], gold(9));

    // R9 interrupt while idle
    @(negedge clk);
    chk(!busy, "R9 idle before interrupt", busy, 0);
    snap();
    sefi = 1;
    @(negedge clk);
    sefi = 0;
    while (user_offline) @(negedge clk);
    chk(rst_cyc - s_rst == RC && wtot() == NA, "R9 idle interrupt recovery", wtot(), NA);

    // R1 reset clears status
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!persist_fault && err_count == 0 && !busy, "R1 reset clears", err_count, 0);
    chk(order_bad == 0, "R3 order over run", order_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule